// File: doc/BRIEF.md
# Radio Byte Queue with Level Flags

This block is a byte-wide first-in first-out store placed between the bit shifter of a radio modem and the data port of a host serial interface. On receive it collects demodulated bytes that the host drains later. On transmit it holds bytes that the host loads for the modem to send. It reports a full flag, an active-low empty indication (a "holds data" flag), a level flag against a host-set threshold, and a sticky overrun flag. Writing 1 to the overrun clear input drops the flag and discards everything stored.

The push side is a stream input with a valid strobe. Its ready output is advisory: it is low while the store is full. The producer is a radio, which cannot be paused, so a byte offered while ready is low is not held back. That byte is dropped and the overrun flag is set. The pop side is a plain valid/ready stream. A byte leaves when both valid and ready are high on a clock edge, and the data stays stable while valid is high and ready is low.

In receive mode, filling is gated. In one fill method the gate opens after a sync detection pulse and stays open until receive mode ends. In the other method a host fill bit opens and closes the gate directly. Outside receive mode the gate is always open, so the host can load transmit bytes, and it can drain received bytes while the radio is in standby.

Top module: `radio_byte_queue`

## Requirements
- R1: The store holds up to 64 bytes. `full_flag` is 1 exactly when 64 bytes are held, and `push_ready` is 0 while `full_flag` is 1.
- R2: `has_data` (the active-low empty indication) and `pop_valid` are 0 exactly when no byte is held.
- R3: Bytes leave through `pop_data` in the order they were accepted.
- R4: A byte offered through the gate while the store is full sets `overrun_flag` one cycle later. The byte is dropped and the stored bytes are unchanged.
- R5: A 1 on `overrun_clear` clears `overrun_flag` and empties the store on the next edge. A push in the same cycle is discarded.
- R6: `irq_level` is 1 exactly when the number of held bytes is greater than the 6-bit `level_thresh`. With a threshold of 0 it rises on the first byte.
- R7: A push and a pop on the same edge, with the store neither empty nor full, leave the byte count unchanged.
- R8: When `rx_active`=1 and `fill_sel`=0 (fill on sync), offered bytes are dropped until a cycle after a `sync_hit` pulse. After that the gate stays open until `rx_active` returns to 0, and the next receive period starts closed again.
- R9: When `rx_active`=1 and `fill_sel`=1 (host fill), a byte is accepted only while `fill_manual` is 1.
- R10: When `rx_active`=0, pushes are accepted whenever the store is not full, and pops work in every mode, so received bytes can be read in standby.
- R11: After reset the store is empty, and `overrun_flag`, `full_flag`, `irq_level` and `irq_full` are 0.
- R12: `irq_full` follows `full_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | 1 | Byte offered by the shifter |
| push_data | input | 8 | Offered byte |
| push_ready | output | 1 | Space available (advisory) |
| pop_valid | output | 1 | A byte is available |
| pop_data | output | 8 | Oldest held byte |
| pop_ready | input | 1 | Host takes the byte |
| rx_active | input | 1 | Radio is in receive mode |
| fill_sel | input | 1 | 0: fill on sync, 1: host fill bit |
| fill_manual | input | 1 | Host fill bit |
| sync_hit | input | 1 | Sync detection pulse |
| level_thresh | input | 6 | Level threshold |
| overrun_clear | input | 1 | Write-one clear of overrun (flushes) |
| full_flag | output | 1 | Store full |
| has_data | output | 1 | Active-low empty indication |
| overrun_flag | output | 1 | Sticky overrun |
| irq_level | output | 1 | Count above threshold |
| irq_full | output | 1 | Full interrupt |

## Verification
The bench fills the store to the 64-byte limit and then offers one more byte. A design that let this byte in, or that wrapped a pointer, would corrupt the oldest entry or lose the full flag. The bench also drains all 64 bytes to show the contents survive an overrun. It checks the threshold flag on both sides of the limit, including a threshold of zero, where an off-by-one design would wait for a second byte. It pops and pushes in the same cycle, where a design with an edge-priority error would gain or lose a count. It also tries the gate in both fill methods, before and after sync and across a receive period, because a gate that fails to re-close would admit noise bytes.

// File: rtl/radio_byte_queue_pkg.sv
package radio_byte_queue_pkg;
  typedef enum logic {
    FILL_ON_SYNC = 1'b0,
    FILL_BY_HOST = 1'b1
  } fill_mode_e;
endpackage

// File: rtl/rbq_store.sv
module rbq_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          flush,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      count <= count + CW'(wr_en) - CW'(rd_en);
    end
  end

  assign rd_data = mem[rd_ptr];

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_pushpop_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && !flush) |=> $stable(count));
  assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));
endmodule

// File: rtl/rbq_flags.sv
module rbq_flags #(
  parameter int DEPTH = 64,
  parameter int CW    = 7,
  parameter int TW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [TW-1:0] thresh,
  input  logic          ovr_set,
  input  logic          ovr_clr,
  output logic          full,
  output logic          nonempty,
  output logic          above,
  output logic          ovr
);
  assign full     = (count == CW'(DEPTH));
  assign nonempty = (count != '0);
  assign above    = (count > CW'(thresh));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovr <= 1'b0;
    else if (ovr_clr) ovr <= 1'b0;
    else if (ovr_set) ovr <= 1'b1;
  end

  assert_overrun_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_set && !ovr_clr) |=> ovr);
  assert_overrun_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_clr |=> !ovr);
  assert_overrun_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set |-> full);
endmodule

// File: rtl/rbq_gate.sv
module rbq_gate
  import radio_byte_queue_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rx_active,
  input  logic fill_sel,
  input  logic fill_manual,
  input  logic sync_hit,
  output logic open
);
  logic armed;
  fill_mode_e mode;
  assign mode = fill_mode_e'(fill_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          armed <= 1'b0;
    else if (!rx_active) armed <= 1'b0;
    else if (sync_hit)   armed <= 1'b1;
  end

  always_comb begin
    if (!rx_active)                open = 1'b1;
    else if (mode == FILL_BY_HOST) open = fill_manual;
    else                           open = armed;
  end

  assert_arm_needs_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(sync_hit));
  assert_arm_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_active |=> !armed);
endmodule

// File: rtl/radio_byte_queue.sv
module radio_byte_queue #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  output logic          push_ready,
  output logic          pop_valid,
  output logic [DW-1:0] pop_data,
  input  logic          pop_ready,
  input  logic          rx_active,
  input  logic          fill_sel,
  input  logic          fill_manual,
  input  logic          sync_hit,
  input  logic [AW-1:0] level_thresh,
  input  logic          overrun_clear,
  output logic          full_flag,
  output logic          has_data,
  output logic          overrun_flag,
  output logic          irq_level,
  output logic          irq_full
);
  logic          gate_open, offered, wr_en, rd_en, ovr_set;
  logic [CW-1:0] count;

  rbq_gate u_gate (
    .clk(clk), .rst_n(rst_n), .rx_active(rx_active), .fill_sel(fill_sel),
    .fill_manual(fill_manual), .sync_hit(sync_hit), .open(gate_open)
  );

  assign offered = push_valid && gate_open;
  assign wr_en   = offered && !full_flag && !overrun_clear;
  assign ovr_set = offered && full_flag && !overrun_clear;
  assign rd_en   = pop_valid && pop_ready && !overrun_clear;

  rbq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(push_data),
    .rd_en(rd_en), .flush(overrun_clear), .rd_data(pop_data), .count(count)
  );

  rbq_flags #(.DEPTH(DEPTH), .CW(CW), .TW(AW)) u_flags (
    .clk(clk), .rst_n(rst_n), .count(count), .thresh(level_thresh),
    .ovr_set(ovr_set), .ovr_clr(overrun_clear), .full(full_flag),
    .nonempty(has_data), .above(irq_level), .ovr(overrun_flag)
  );

  assign push_ready = !full_flag;
  assign pop_valid  = has_data;
  assign irq_full   = full_flag;

  assert_pop_data_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && !pop_ready && !push_valid && !overrun_clear) |=> $stable(pop_data));
  assert_full_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full_flag && !rd_en && !overrun_clear) |=> full_flag);
endmodule

// File: tb/radio_byte_queue_test.sv
module radio_byte_queue_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_valid = 0, pop_ready = 0, rx_active = 0, fill_sel = 0;
  logic       fill_manual = 0, sync_hit = 0, overrun_clear = 0;
  logic [7:0] push_data = 0;
  logic [5:0] level_thresh = 6'd63;
  logic       push_ready, pop_valid, full_flag, has_data, overrun_flag, irq_level, irq_full;
  logic [7:0] pop_data;

  int runs = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  radio_byte_queue uut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .push_ready(push_ready), .pop_valid(pop_valid), .pop_data(pop_data),
    .pop_ready(pop_ready), .rx_active(rx_active), .fill_sel(fill_sel),
    .fill_manual(fill_manual), .sync_hit(sync_hit), .level_thresh(level_thresh),
    .overrun_clear(overrun_clear), .full_flag(full_flag), .has_data(has_data),
    .overrun_flag(overrun_flag), .irq_level(irq_level), .irq_full(irq_full)
  );

  task automatic chk(input string req, input int act, input int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    push_valid = 1; push_data = b;
    @(negedge clk);
    push_valid = 0;
  endtask

  task automatic pop_expect(input string req, input logic [7:0] b);
    chk(req, pop_valid, 1);
    chk(req, pop_data, b);
    pop_ready = 1;
    @(negedge clk);
    pop_ready = 0;
  endtask

  task automatic flush();
    overrun_clear = 1;
    @(negedge clk);
    overrun_clear = 0;
  endtask

  task automatic t_reset();
    chk("R11 has_data", has_data, 0);
    chk("R11 overrun", overrun_flag, 0);
    chk("R11 full", full_flag, 0);
    chk("R11 irq_level", irq_level, 0);
    chk("R11 irq_full", irq_full, 0);
    chk("R2 pop_valid", pop_valid, 0);
  endtask

  task automatic t_order();
    rx_active = 0;
    for (int i = 0; i < 5; i++) push(8'h10 + 8'(i));
    chk("R10 tx load", has_data, 1);
    for (int i = 0; i < 5; i++) pop_expect("R3 order", 8'h10 + 8'(i));
    chk("R2 empty again", has_data, 0);
  endtask

  task automatic t_threshold();
    level_thresh = 6'd3;
    for (int i = 0; i < 3; i++) push(8'(i));
    chk("R6 at threshold", irq_level, 0);
    push(8'h33);
    chk("R6 above threshold", irq_level, 1);
    pop_expect("R6 pop", 8'h00);
    chk("R6 back to threshold", irq_level, 0);
    flush();
    level_thresh = 6'd0;
    chk("R6 zero empty", irq_level, 0);
    push(8'hA1);
    chk("R6 zero first byte", irq_level, 1);
    flush();
    level_thresh = 6'd63;
  endtask

  task automatic t_full_overrun();
    for (int i = 0; i < 64; i++) push(8'(i) ^ 8'h5A);
    chk("R1 full", full_flag, 1);
    chk("R1 ready low", push_ready, 0);
    chk("R12 irq_full", irq_full, 1);
    chk("R4 no overrun yet", overrun_flag, 0);
    push(8'hEE);
    chk("R4 overrun set", overrun_flag, 1);
    chk("R4 still full", full_flag, 1);
    pop_expect("R4 first kept", 8'h5A);
    chk("R1 not full", full_flag, 0);
    for (int i = 1; i < 64; i++) pop_expect("R4 contents", 8'(i) ^ 8'h5A);
    chk("R4 dropped byte absent", pop_valid, 0);
    chk("R4 sticky", overrun_flag, 1);
    push(8'h77); push(8'h78);
    push_valid = 1; push_data = 8'h79; overrun_clear = 1;
    @(negedge clk);
    push_valid = 0; overrun_clear = 0;
    chk("R5 flag cleared", overrun_flag, 0);
    chk("R5 flushed", has_data, 0);
  endtask

  task automatic t_simul();
    level_thresh = 6'd1;
    push(8'hC0); push(8'hC1);
    chk("R7 before", irq_level, 1);
    chk("R7 head", pop_data, 8'hC0);
    push_valid = 1; push_data = 8'hC2; pop_ready = 1;
    @(negedge clk);
    push_valid = 0; pop_ready = 0;
    chk("R7 count kept", irq_level, 1);
    pop_expect("R7 next", 8'hC1);
    chk("R7 one left", irq_level, 0);
    pop_expect("R7 last", 8'hC2);
    chk("R7 empty", has_data, 0);
    level_thresh = 6'd63;
  endtask

  task automatic t_sync();
    rx_active = 1; fill_sel = 0;
    push(8'h01);
    chk("R8 dropped before sync", has_data, 0);
    sync_hit = 1;
    @(negedge clk);
    sync_hit = 0;
    push(8'h02);
    push(8'h03);
    chk("R8 accepted after sync", has_data, 1);
    rx_active = 0;
    @(negedge clk);
    pop_expect("R10 standby read", 8'h02);
    rx_active = 1;
    push(8'h04);
    pop_expect("R8 rearm needed", 8'h03);
    chk("R8 closed again", has_data, 0);
    rx_active = 0;
  endtask

  task automatic t_manual();
    rx_active = 1; fill_sel = 1; fill_manual = 0;
    push(8'h44);
    chk("R9 fill bit low", has_data, 0);
    fill_manual = 1;
    push(8'h45);
    fill_manual = 0;
    push(8'h46);
    pop_expect("R9 fill bit high", 8'h45);
    chk("R9 closed again", has_data, 0);
    rx_active = 0; fill_sel = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order();
    t_threshold();
    t_full_overrun();
    t_simul();
    t_sync();
    t_manual();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      runs++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule